// File: doc/BRIEF.md
# Configurable SPI Master/Slave Engine

This block moves 8- or 16-bit words over a four-wire serial link, most significant bit first. A 16-bit control register sets the role, the word width, the clock idle level, the clock edge on which outgoing data changes and, in the master role, where inside each bit the incoming line is sampled. The same register can release the clock pin and the data-out pin to general I/O. In the slave role it can also make the block obey a slave-select input.

As master, writing the transmit port starts a transfer. Each bit lasts four system clocks, taken from a fixed divide-by-four. As slave, the block follows an external serial clock, and its transmit word is taken from the last value written. When a word completes, it lands in the receive register and a done flag rises. Reading the receive register clears the flag.

Top module: `spi_xcvr`

## Requirements
- R1: After reset every control bit reads 0. Control bits 12 down to 5 read back as written. Bits 15..13 and 4..0 always read 0.
- R2: In the master role (bit 5 = 1), a transmit write while idle starts a transfer. The transfer gives exactly one idle-to-active serial clock transition per bit, each bit lasting 4 system clocks. The done flag is set 4*W clocks after the write edge (W = 8 or 16). Outside transfers the clock rests at the level of bit 6 (1 = idle high).
- R3: Data leaves and enters MSB first. Bit 10 selects a 16-bit word (1) or an 8-bit word (0). In 8-bit mode the receive register's upper byte reads 0.
- R4: With bit 8 = 0, output data changes on the idle-to-active clock edge. With bit 8 = 1, it changes on the active-to-idle edge. A peer that samples on the other edge receives the transmit word intact, in both roles.
- R5: In the master role, bit 9 = 0 samples the input at the end of the 2nd system clock of each bit. Bit 9 = 1 samples it at the end of the 4th.
- R6: In the slave role, the block shifts on the external clock under the same edge rule as R4. It sends the word last written to the transmit port and receives the word presented on the data input.
- R7: In the slave role with bit 7 = 1, a high slave-select stops the data-out enable and discards a partial transfer, restarting the bit count. With bit 7 = 0, slave-select has no effect.
- R8: The clock output enable is high only in the master role with bit 12 = 0.
- R9: With bit 11 = 1, the data output enable stays low in both roles.
- R10: A completed transfer sets the done flag. A receive read strobe clears it. The receive register holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 16 | Control register write value |
| ctrlRdata | output | 16 | Control register read value |
| txWe | input | 1 | Transmit word write strobe (starts a master transfer) |
| txData | input | 16 | Transmit word |
| rxRe | input | 1 | Receive register read strobe |
| rxData | output | 16 | Receive register |
| rxDone | output | 1 | Transfer-complete flag |
| sckIn | input | 1 | Serial clock from the pin (slave role) |
| sckOut | output | 1 | Serial clock driven in the master role |
| sckOe | output | 1 | Serial clock output enable |
| sdiIn | input | 1 | Serial data input |
| sdoOut | output | 1 | Serial data output |
| sdoOe | output | 1 | Serial data output enable |
| ssIn | input | 1 | Slave-select input, active low |

## Verification
The checks assume that the control register is not rewritten while a word is in flight. They also assume that bit 9 stays 0 whenever the slave role is chosen. In the slave role, the serial clock and select lines are taken to change no faster than once every few system clocks and to stay at the idle level when the role is entered. The bench respects all of this. Every configuration, random or directed, is written between transfers. Slave-role configurations are entered through a master-role write that first parks the serial clock at the new idle level. The external clock is driven with three system clocks per half period.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // control bits 12 down to 5, most significant first
  typedef struct packed {
    logic disSck;
    logic disSdo;
    logic wide;
    logic smpEnd;
    logic cke;
    logic ssEn;
    logic ckp;
    logic master;
  } ctrlBits_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } dpStrobe_t;

endpackage

// File: rtl/spi_xcvr_ctrl.sv
module spi_xcvr_ctrl
  import spi_xcvr_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [15:0] ctrlWdata,
  input  logic        txWe,
  input  logic        sckIn,
  input  logic        ssIn,
  output ctrlBits_t   cfg,
  output dpStrobe_t   stb,
  output logic        sckOut,
  output logic        sckOe,
  output logic        sdoOe,
  output logic        busy
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = $clog2(CLK_DIV);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             sckQ;
  logic             unusedCtrl;

  assign unusedCtrl = ^{ctrlWdata[15:13], ctrlWdata[4:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfg <= '0;
    else if (ctrlWe) cfg <= ctrlWdata[12:5];
  end

  assign lastIdx = cfg.wide ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);

  // master timing
  logic phEnd, lastBit, mStart, mSample;
  assign phEnd   = (ph == PH_W'(CLK_DIV - 1));
  assign lastBit = (bitCnt == lastIdx);
  assign mStart  = cfg.master && txWe && !busy;
  assign mSample = busy && (cfg.smpEnd ? phEnd : (ph == PH_W'(HALF - 1)));

  // slave edge detection on the external clock
  logic ssBlock, sEnable, sckEdge, toActive, sSampleEdge, sSample;
  assign ssBlock     = cfg.ssEn && ssIn;
  assign sEnable     = !cfg.master && !ssBlock;
  assign sckEdge     = (sckIn != sckQ);
  assign toActive    = sckEdge && (sckIn != cfg.ckp);
  assign sSampleEdge = cfg.cke ? toActive : (sckEdge && !toActive);
  assign sSample     = sEnable && sSampleEdge;

  always_comb begin
    stb.load   = mStart || (!cfg.master && bitCnt == '0);
    stb.sample = mSample || sSample;
    stb.shift  = (busy && phEnd && !lastBit)
               || (sEnable && sckEdge && !sSampleEdge && bitCnt != '0);
    stb.finish = (busy && phEnd && lastBit) || (sSample && lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ   <= 1'b0;
      busy   <= 1'b0;
      ph     <= '0;
      bitCnt <= '0;
    end else begin
      sckQ <= sckIn;
      if (cfg.master) begin
        if (mStart) begin
          busy   <= 1'b1;
          ph     <= '0;
          bitCnt <= '0;
        end else if (busy) begin
          ph <= phEnd ? '0 : ph + 1'b1;
          if (phEnd) begin
            if (lastBit) begin
              busy   <= 1'b0;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
      end else begin
        busy <= 1'b0;
        ph   <= '0;
        if (!sEnable)     bitCnt <= '0;
        else if (sSample) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (cfg.master && busy)
      sckOut = cfg.ckp ^ (cfg.cke ? (ph >= PH_W'(HALF)) : (ph < PH_W'(HALF)));
    else
      sckOut = cfg.ckp;
  end

  assign sckOe = cfg.master && !cfg.disSck;
  assign sdoOe = !cfg.disSdo && (cfg.master || !ssBlock);

endmodule

// File: rtl/spi_xcvr_dp.sv
module spi_xcvr_dp
  import spi_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide,
  input  dpStrobe_t         stb,
  input  logic              txWe,
  input  logic [WORD_W-1:0] txData,
  input  logic              sdiIn,
  input  logic              rxRe,
  output logic [WORD_W-1:0] rxData,
  output logic              rxDone,
  output logic              sdoBit
);
  logic [WORD_W-1:0] txReg, txSh, rxSh, rxNext, rxCap;

  assign rxNext = {rxSh[WORD_W-2:0], sdiIn};
  assign rxCap  = stb.sample ? rxNext : rxSh;
  assign sdoBit = wide ? txSh[WORD_W-1] : txSh[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      txSh   <= '0;
      rxSh   <= '0;
      rxData <= '0;
      rxDone <= 1'b0;
    end else begin
      if (txWe) txReg <= txData;
      if (stb.load)       txSh <= txWe ? txData : txReg;
      else if (stb.shift) txSh <= {txSh[WORD_W-2:0], 1'b0};
      if (stb.sample) rxSh <= rxNext;
      if (stb.finish) begin
        rxData <= wide ? rxCap : {{(WORD_W-BYTE_W){1'b0}}, rxCap[BYTE_W-1:0]};
        rxDone <= 1'b1;
      end else if (rxRe) begin
        rxDone <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [15:0] ctrlWdata,
  output logic [15:0] ctrlRdata,
  input  logic        txWe,
  input  logic [15:0] txData,
  input  logic        rxRe,
  output logic [15:0] rxData,
  output logic        rxDone,
  input  logic        sckIn,
  output logic        sckOut,
  output logic        sckOe,
  input  logic        sdiIn,
  output logic        sdoOut,
  output logic        sdoOe,
  input  logic        ssIn
);
  ctrlBits_t cfg;
  dpStrobe_t dpStb;
  logic      mstBusy;
  logic      finishStb;

  spi_xcvr_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .txWe(txWe), .sckIn(sckIn), .ssIn(ssIn), .cfg(cfg), .stb(dpStb),
    .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe), .busy(mstBusy)
  );

  spi_xcvr_dp u_dp (
    .clk(clk), .rstN(rstN), .wide(cfg.wide), .stb(dpStb), .txWe(txWe),
    .txData(txData), .sdiIn(sdiIn), .rxRe(rxRe), .rxData(rxData),
    .rxDone(rxDone), .sdoBit(sdoOut)
  );

  assign ctrlRdata = {3'b000, cfg, 5'b00000};
  assign finishStb = dpStb.finish;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] ctrlRdata,
  input logic        sckOut,
  input logic        sckOe,
  input logic        sdoOe,
  input logic        ssIn,
  input logic        rxRe,
  input logic [15:0] rxData,
  input logic        rxDone,
  input logic        mstBusy,
  input logic        finishStb
);
  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[15:13] == 3'b000 && ctrlRdata[4:0] == 5'b00000);

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mstBusy) |-> sckOut == ctrlRdata[6]);

  p_master_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mstBusy) |-> rxDone);

  p_ss_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRdata[5] && ctrlRdata[7] && ssIn) |-> !sdoOe);

  p_sck_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    sckOe |-> (ctrlRdata[5] && !ctrlRdata[12]));

  p_sdo_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[11] |-> !sdoOe);

  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxRe && !finishStb) |=> !rxDone);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !finishStb |=> $stable(rxData));

endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlRdata(ctrlRdata), .sckOut(sckOut),
  .sckOe(sckOe), .sdoOe(sdoOe), .ssIn(ssIn), .rxRe(rxRe), .rxData(rxData),
  .rxDone(rxDone), .mstBusy(mstBusy), .finishStb(finishStb)
);

// File: tb/tb_spi_xcvr.sv
`timescale 1ns/1ps
module tb_spi_xcvr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWdata = '0;
  logic [15:0] ctrlRdata;
  logic        txWe = 1'b0;
  logic [15:0] txData = '0;
  logic        rxRe = 1'b0;
  logic [15:0] rxData;
  logic        rxDone;
  logic        sckIn = 1'b0;
  logic        sckOut, sckOe;
  logic        sdiIn = 1'b0;
  logic        sdoOut, sdoOe;
  logic        ssIn = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  logic cfgMaster, cfgWide, cfgSmp, cfgCke, cfgCkp;

  always #2 clk = ~clk;

  spi_xcvr dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .txWe(txWe), .txData(txData), .rxRe(rxRe),
    .rxData(rxData), .rxDone(rxDone), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .sdiIn(sdiIn), .sdoOut(sdoOut), .sdoOe(sdoOe), .ssIn(ssIn)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCfg(input logic master, input logic wide, input logic smp,
                                        input logic cke, input logic ssen, input logic ckp,
                                        input logic disSck, input logic disSdo);
    return {3'b000, disSck, disSdo, wide, smp, cke, ssen, ckp, master, 5'b00000};
  endfunction

  function automatic logic [15:0] maskW(input logic [15:0] v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic wrCtrl(input logic [15:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic setup(input logic master, input logic wide, input logic smp, input logic cke,
                       input logic ssen, input logic ckp, input logic disSck, input logic disSdo);
    cfgMaster = master; cfgWide = wide; cfgSmp = smp; cfgCke = cke; cfgCkp = ckp;
    wrCtrl(mkCfg(1'b1, wide, 1'b0, cke, 1'b0, ckp, 1'b0, 1'b0));
    sckIn = ckp;
    repeat (2) @(negedge clk);
    wrCtrl(mkCfg(master, wide, smp, cke, ssen, ckp, disSck, disSdo));
  endtask

  task automatic readRx(input logic [15:0] expv);
    @(negedge clk); rxRe = 1'b1;
    @(negedge clk); rxRe = 1'b0;
    check(rxDone == 1'b0, "R10 done clears on read", {15'b0, rxDone}, 16'h0000);
    check(rxData == expv, "R10 rx held after read", rxData, expv);
  endtask

  task automatic runMaster(input logic [15:0] txv, input logic [15:0] a, input logic [15:0] b);
    int w;
    int lead;
    logic [15:0] got;
    logic prev;
    logic [15:0] expRx;
    w = cfgWide ? 16 : 8;
    lead = 0; got = '0; prev = cfgCkp;
    @(negedge clk); txWe = 1'b1; txData = txv;
    @(negedge clk); txWe = 1'b0;
    for (int t = 0; t < 4 * w; t++) begin
      logic s, act;
      int bi;
      s = sckOut;
      if (s != prev) begin
        act = (s != cfgCkp);
        if (act) lead++;
        if (cfgCke ? act : !act) got = {got[14:0], sdoOut};
      end
      prev = s;
      bi = t / 4;
      sdiIn = ((t % 4) >= 2) ? b[w-1-bi] : a[w-1-bi];
      @(negedge clk);
    end
    expRx = maskW(cfgSmp ? b : a, cfgWide);
    check(rxDone == 1'b1, "R2 done after 4*W clocks", {15'b0, rxDone}, 16'h0001);
    check(rxData == expRx, "R5 R3 master sample point / width", rxData, expRx);
    check(maskW(got, cfgWide) == maskW(txv, cfgWide), "R4 R3 master output bits", maskW(got, cfgWide), maskW(txv, cfgWide));
    check(lead == w, "R2 one leading edge per bit", 16'(lead), 16'(w));
    check(sckOut == cfgCkp, "R2 clock idle level", {15'b0, sckOut}, {15'b0, cfgCkp});
    readRx(expRx);
  endtask

  task automatic runSlave(input logic [15:0] txv, input logic [15:0] mosi, input int nbits,
                          output logic [15:0] got);
    int w;
    w = cfgWide ? 16 : 8;
    got = '0;
    @(negedge clk); txWe = 1'b1; txData = txv;
    @(negedge clk); txWe = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic bitv;
      bitv = mosi[w-1-i];
      if (!cfgCke) begin
        sckIn = ~cfgCkp; sdiIn = bitv;
        repeat (3) @(negedge clk);
        got = {got[14:0], sdoOut};
        sckIn = cfgCkp;
        repeat (3) @(negedge clk);
      end else begin
        sdiIn = bitv;
        repeat (3) @(negedge clk);
        got = {got[14:0], sdoOut};
        sckIn = ~cfgCkp;
        repeat (3) @(negedge clk);
        sckIn = cfgCkp;
        repeat (3) @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic slaveFull(input logic [15:0] txv, input logic [15:0] mosi, input string tag);
    logic [15:0] got;
    logic [15:0] expRx;
    runSlave(txv, mosi, cfgWide ? 16 : 8, got);
    expRx = maskW(mosi, cfgWide);
    check(rxDone == 1'b1, "R10 R6 slave done", {15'b0, rxDone}, 16'h0001);
    check(rxData == expRx, tag, rxData, expRx);
    check(maskW(got, cfgWide) == maskW(txv, cfgWide), "R4 R6 slave output bits", maskW(got, cfgWide), maskW(txv, cfgWide));
    readRx(expRx);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [15:0] part;
    void'($urandom(32'h5EED1234));
    cfgMaster = 0; cfgWide = 0; cfgSmp = 0; cfgCke = 0; cfgCkp = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdata == 16'h0000, "R1 reset value", ctrlRdata, 16'h0000);
    check(rxDone == 1'b0, "R10 done low after reset", {15'b0, rxDone}, 16'h0000);
    check(sckOe == 1'b0, "R8 slave default no clock drive", {15'b0, sckOe}, 16'h0000);

    wrCtrl(16'hFFFF);
    check(ctrlRdata == 16'h1FE0, "R1 readback mask", ctrlRdata, 16'h1FE0);
    check(sckOe == 1'b0, "R8 clock released by bit 12", {15'b0, sckOe}, 16'h0000);
    check(sdoOe == 1'b0, "R9 data out released by bit 11", {15'b0, sdoOe}, 16'h0000);
    wrCtrl(16'h0000);

    // master directed corners
    setup(1, 0, 0, 0, 0, 0, 0, 0);
    check(sckOe == 1'b1, "R8 master drives clock", {15'b0, sckOe}, 16'h0001);
    runMaster(16'h00A5, 16'h003C, 16'h00C3);
    setup(1, 1, 1, 1, 0, 1, 0, 0);
    runMaster(16'h8E71, 16'h1234, 16'hBEEF);
    setup(1, 1, 0, 1, 0, 0, 0, 1);
    check(sdoOe == 1'b0, "R9 master data out released", {15'b0, sdoOe}, 16'h0000);
    runMaster(16'hF00D, 16'h5AA5, 16'h0FF0);
    setup(1, 0, 1, 0, 0, 1, 1, 0);
    check(sckOe == 1'b0, "R8 master clock released", {15'b0, sckOe}, 16'h0000);
    runMaster(16'h0081, 16'h0066, 16'h0099);

    // slave directed corners
    setup(0, 1, 0, 0, 0, 0, 0, 0);
    check(sckOe == 1'b0, "R8 slave never drives clock", {15'b0, sckOe}, 16'h0000);
    slaveFull(16'hC3A5, 16'h7E81, "R6 R3 slave 16-bit mode");
    setup(0, 0, 0, 1, 0, 1, 0, 0);
    slaveFull(16'h0096, 16'h005B, "R6 R3 slave 8-bit mode");

    // slave select: abort a partial word, then a full word
    setup(0, 0, 0, 1, 1, 0, 0, 0);
    check(sdoOe == 1'b1, "R7 select low drives data", {15'b0, sdoOe}, 16'h0001);
    runSlave(16'h00E7, 16'h00FF, 3, part);
    ssIn = 1'b1;
    repeat (3) @(negedge clk);
    check(sdoOe == 1'b0, "R7 select high releases data", {15'b0, sdoOe}, 16'h0000);
    check(rxDone == 1'b0, "R7 partial word not delivered", {15'b0, rxDone}, 16'h0000);
    ssIn = 1'b0;
    repeat (2) @(negedge clk);
    slaveFull(16'h0042, 16'h0029, "R7 full word after abort");

    // select ignored when bit 7 is 0
    setup(0, 0, 0, 0, 0, 0, 0, 0);
    ssIn = 1'b1;
    repeat (2) @(negedge clk);
    check(sdoOe == 1'b1, "R7 select ignored, data driven", {15'b0, sdoOe}, 16'h0001);
    slaveFull(16'h003C, 16'h00D2, "R7 transfer with select ignored");
    ssIn = 1'b0;

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic m, wd, sp, ck, cp;
      logic [15:0] tv, av, bv;
      m  = 1'($urandom);
      wd = 1'($urandom);
      ck = 1'($urandom);
      cp = 1'($urandom);
      sp = m ? 1'($urandom) : 1'b0;
      tv = 16'($urandom);
      av = 16'($urandom);
      bv = 16'($urandom);
      setup(m, wd, sp, ck, 1'b0, cp, 1'b0, 1'b0);
      if (m) runMaster(tv, av, bv);
      else   slaveFull(tv, av, "R6 random slave word");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule